// File: doc/BRIEF.md
# Flash Read Response Selector

This block sits beside the write-command sequencer of a parallel NOR flash model and decides what each read returns. The sequencer reports the current command state as an 8-bit mode code. Depending on that code, a read returns the word stored in the array, a manufacturer/device identifier, a program/erase status byte, or an entry of a small query-structure ROM. The ROM is built at elaboration from the geometry parameters.

Array words come from an external synchronous memory. On every read strobe the block presents the word address, and the memory answers on the next clock edge. The block registers its own selection at that same edge, so every result leaves the block one clock after its strobe. The status byte is held here and reloaded by the sequencer. Bit 6 of the status byte flips after every read taken in a status mode, so software polling it sees a toggle.

The block also tracks whether the device is in direct-array mode. Any write made while the sequencer is idle takes the device out of that mode and clears a read counter. Reads that arrive while the sequencer is idle and the device is out of direct-array mode are counted. Once the count passes a limit, the device falls back to direct-array mode.

Top module: `flash_read_mux`

## Requirements
- R1: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high, and `rd_data` holds that read's result in that cycle.
- R2: In mode 0x00 (read) and mode 0x80 (erase unlock pending), the result is the memory word at word address `rd_off >> log2(BUS_BYTES)`.
- R3: In mode 0x90 (identifier), word offset 0 returns `ID0`, word offset 1 returns `ID1`, and word offset 2 returns 0.
- R4: In mode 0x90, word offsets 0x0E and 0x0F return `ID2` and `ID3`. When that identifier equals 0x00FF, the array word is returned instead. Every other word offset also returns the array word.
- R5: In modes 0xA0, 0x10 and 0x30, the result is the status byte, zero-extended. Bit 6 of the status byte inverts after each such read. A cycle with `status_ld` high loads `status_val` and takes priority over the toggle.
- R6: In mode 0x98 (query), a word offset below 0x52 returns the ROM byte and any higher offset returns 0. The ROM holds 0x51, 0x52, 0x59 at 0x10..0x12, log2 of the chip size in bytes at 0x27, `NUM_SECTORS-1` at 0x2D, and `SECTOR_BYTES>>8` at 0x2F.
- R7: `array_mode` is 1 after reset and is 0 in the cycle after `idle_wr`, which also clears the read counter. A read with `wc_idle` high and `array_mode` low is counted. The read that would take the count past `LAZY_LIMIT` (default 42) sets `array_mode` instead. Reads with `wc_idle` low are not counted.
- R8: Any other mode code returns the array word and raises `seq_reset` together with `rd_valid` for that read. For recognised modes, `seq_reset` stays low.
- R9: The word offset used for the identifier and query decodes comes only from the low 8 bits of `rd_off`. Higher bits do not change those results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_off | input | ADDR_W | Byte offset of the read |
| mode | input | 8 | Command state from the sequencer |
| wc_idle | input | 1 | Sequencer write cycle is idle |
| idle_wr | input | 1 | A write was taken while idle |
| status_ld | input | 1 | Load the status byte |
| status_val | input | 8 | Status value to load |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | ADDR_W-log2(BUS_BYTES) | Memory word address |
| mem_rdata | input | DATA_W | Memory word, one clock after address |
| rd_valid | output | 1 | Result valid |
| rd_data | output | DATA_W | Read result |
| seq_reset | output | 1 | Request for the sequencer to return to idle |
| array_mode | output | 1 | Direct-array mode flag |

## Verification
Every read result, including `seq_reset`, is due in the single cycle after its strobe. The mode flag changes on the edge that samples `idle_wr` or the limit-crossing read. The driver pushes an expected item when it raises `rd_en`. The monitor samples on the falling edge, so it sees `rd_valid` one edge later and pops and compares exactly then. A result with no queued item, or a leftover item at the end, is a failure. Mode-flag checks are made on the falling edge right after the sampling edge.

// File: rtl/flash_rdmux_pkg.sv
package flash_rdmux_pkg;

   localparam logic [7:0] MODE_READ     = 8'h00;
   localparam logic [7:0] MODE_ERS_PEND = 8'h80;
   localparam logic [7:0] MODE_IDENT    = 8'h90;
   localparam logic [7:0] MODE_PROG     = 8'hA0;
   localparam logic [7:0] MODE_CHIP_ERS = 8'h10;
   localparam logic [7:0] MODE_SECT_ERS = 8'h30;
   localparam logic [7:0] MODE_QUERY    = 8'h98;

   localparam logic [7:0] QUERY_LEN     = 8'h52;

   // Query-structure ROM, computed from the geometry.
   function automatic logic [7:0] query_byte(input logic [7:0] idx,
                                             input int sect_b,
                                             input int nsect,
                                             input int chip_log2);
      int nm1;
      logic [7:0] b;
      nm1 = nsect - 1;
      case (idx)
         8'h10: b = 8'h51;
         8'h11: b = 8'h52;
         8'h12: b = 8'h59;
         8'h13: b = 8'h02;
         8'h15: b = 8'h31;
         8'h1B: b = 8'h27;
         8'h1C: b = 8'h36;
         8'h1F: b = 8'h07;
         8'h21: b = 8'h09;
         8'h22: b = 8'h0C;
         8'h23: b = 8'h01;
         8'h25: b = 8'h0A;
         8'h26: b = 8'h0D;
         8'h27: b = 8'(chip_log2);
         8'h28: b = 8'h02;
         8'h2C: b = 8'h01;
         8'h2D: b = 8'(nm1);
         8'h2E: b = 8'(nm1 >> 8);
         8'h2F: b = 8'(sect_b >> 8);
         8'h30: b = 8'(sect_b >> 16);
         8'h31: b = 8'h50;
         8'h32: b = 8'h52;
         8'h33: b = 8'h49;
         8'h34: b = 8'h31;
         8'h35: b = 8'h30;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/frm_word_index.sv
module frm_word_index #(
   parameter int BUS_BYTES = 2,
   parameter int ADDR_W    = 10,
   localparam int SH       = $clog2(BUS_BYTES),
   localparam int WADDR_W  = ADDR_W - SH
) (
   input  logic [ADDR_W-1:0]  byte_off,
   output logic [7:0]         word_off,
   output logic [WADDR_W-1:0] word_addr
);

   generate
      if (SH == 0) begin : g_byte
         assign word_off  = byte_off[7:0];
         assign word_addr = byte_off;
      end else begin : g_wide
         assign word_off  = {{SH{1'b0}}, byte_off[7:SH]};
         assign word_addr = byte_off[ADDR_W-1:SH];
      end
   endgenerate

endmodule

// File: rtl/frm_status_reg.sv
module frm_status_reg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [7:0] ld_val,
   input  logic       rd_stat,
   output logic [7:0] status_o
);

   logic [7:0] status_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        status_q <= 8'h00;
      else if (ld)       status_q <= ld_val;
      else if (rd_stat)  status_q <= status_q ^ 8'h40;
   end

   assign status_o = status_q;

   // R5: each status read flips bit 6 and leaves the other bits alone
   p_status_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !ld) |=> (status_q[6] != $past(status_q[6])) &&
                           (status_q[5:0] == $past(status_q[5:0])));

   // R5: a load takes priority
   p_status_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> status_q == $past(ld_val));

endmodule

// File: rtl/frm_lazy_ctr.sv
module frm_lazy_ctr #(
   parameter int LIMIT = 42,
   localparam int CW   = $clog2(LIMIT + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en,
   input  logic wc_idle,
   input  logic idle_wr,
   output logic array_mode_o
);

   logic [CW-1:0] cnt_q;
   logic          arr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         arr_q <= 1'b1;
      end else if (idle_wr) begin
         cnt_q <= '0;
         arr_q <= 1'b0;
      end else if (rd_en && wc_idle && !arr_q) begin
         if (cnt_q == CW'(LIMIT)) arr_q <= 1'b1;
         else                     cnt_q <= cnt_q + 1'b1;
      end
   end

   assign array_mode_o = arr_q;

   // R7: an idle write leaves direct-array mode
   p_idle_wr_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idle_wr |=> !arr_q);

   // R7: the return to array mode happens only with a full count
   p_lazy_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arr_q) |-> $past(cnt_q) == CW'(LIMIT));

   // R7: the count never passes the limit
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
   import flash_rdmux_pkg::*;
#(
   parameter int           BUS_BYTES    = 2,
   parameter int           DATA_W       = 16,
   parameter int           SECTOR_BYTES = 256,
   parameter int           NUM_SECTORS  = 4,
   parameter int           LAZY_LIMIT   = 42,
   parameter logic [15:0]  ID0          = 16'h0001,
   parameter logic [15:0]  ID1          = 16'h227E,
   parameter logic [15:0]  ID2          = 16'h2222,
   parameter logic [15:0]  ID3          = 16'h00FF,
   localparam int          ADDR_W       = $clog2(SECTOR_BYTES * NUM_SECTORS),
   localparam int          WADDR_W      = ADDR_W - $clog2(BUS_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_off,
   input  logic [7:0]         mode,
   input  logic               wc_idle,
   input  logic               idle_wr,
   input  logic               status_ld,
   input  logic [7:0]         status_val,
   output logic               mem_rd_en,
   output logic [WADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic               seq_reset,
   output logic               array_mode
);

   localparam logic [15:0] ID_NONE = 16'h00FF;

   generate
      if (!(BUS_BYTES == 1 || BUS_BYTES == 2 || BUS_BYTES == 4)) begin : g_bad_bus
         $error("BUS_BYTES must be 1, 2 or 4");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold a 16-bit identifier");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("chip must span at least 256 bytes");
      end
   endgenerate

   logic [7:0]        word_off;
   logic [7:0]        status_b;
   logic              rd_stat;
   logic              sel_arr;
   logic              unk;
   logic [DATA_W-1:0] alt_d;

   logic              valid_q;
   logic              sel_arr_q;
   logic              unk_q;
   logic [DATA_W-1:0] alt_q;

   frm_word_index #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W)) u_idx (
      .byte_off  (rd_off),
      .word_off  (word_off),
      .word_addr (mem_addr)
   );

   frm_status_reg u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (status_ld),
      .ld_val   (status_val),
      .rd_stat  (rd_stat),
      .status_o (status_b)
   );

   frm_lazy_ctr #(.LIMIT(LAZY_LIMIT)) u_lazy (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_en        (rd_en),
      .wc_idle      (wc_idle),
      .idle_wr      (idle_wr),
      .array_mode_o (array_mode)
   );

   assign mem_rd_en = rd_en;

   always_comb begin
      sel_arr = 1'b1;
      unk     = 1'b0;
      rd_stat = 1'b0;
      alt_d   = '0;
      case (mode)
         MODE_READ, MODE_ERS_PEND: sel_arr = 1'b1;
         MODE_IDENT: begin
            case (word_off)
               8'h00: begin sel_arr = 1'b0; alt_d = DATA_W'(ID0); end
               8'h01: begin sel_arr = 1'b0; alt_d = DATA_W'(ID1); end
               8'h02: begin sel_arr = 1'b0; alt_d = '0; end
               8'h0E: begin
                  sel_arr = (ID2 == ID_NONE);
                  alt_d   = DATA_W'(ID2);
               end
               8'h0F: begin
                  sel_arr = (ID3 == ID_NONE);
                  alt_d   = DATA_W'(ID3);
               end
               default: sel_arr = 1'b1;
            endcase
         end
         MODE_PROG, MODE_CHIP_ERS, MODE_SECT_ERS: begin
            sel_arr = 1'b0;
            rd_stat = rd_en;
            alt_d   = DATA_W'(status_b);
         end
         MODE_QUERY: begin
            sel_arr = 1'b0;
            if (word_off < QUERY_LEN)
               alt_d = DATA_W'(query_byte(word_off, SECTOR_BYTES, NUM_SECTORS, ADDR_W));
            else
               alt_d = '0;
         end
         default: begin
            sel_arr = 1'b1;
            unk     = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         sel_arr_q <= 1'b1;
         unk_q     <= 1'b0;
         alt_q     <= '0;
      end else begin
         valid_q <= rd_en;
         unk_q   <= rd_en && unk;
         if (rd_en) begin
            sel_arr_q <= sel_arr;
            alt_q     <= alt_d;
         end
      end
   end

   assign rd_valid  = valid_q;
   assign seq_reset = unk_q;
   assign rd_data   = sel_arr_q ? mem_rdata : alt_q;

   // R1: a result follows every strobe by one cycle, and only then
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R8: an unrecognised mode asks the sequencer to go idle
   p_unknown_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mode == 8'h55) |=> seq_reset);
   p_reset_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_reset |-> rd_valid);

   // R3: identifier word 0 is returned one cycle later
   p_ident0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mode == MODE_IDENT && rd_off[7:0] == 8'h00) |=> rd_data == DATA_W'(ID0));

endmodule

// File: tb/tb_flash_read_mux.sv
module tb_flash_read_mux;

   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic [9:0]  rd_off = '0;
   logic [7:0]  mode = 8'h00;
   logic        wc_idle = 1'b1;
   logic        idle_wr = 1'b0;
   logic        status_ld = 1'b0;
   logic [7:0]  status_val = '0;
   logic        mem_rd_en;
   logic [8:0]  mem_addr;
   logic [15:0] mem_rdata;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        seq_reset;
   logic        array_mode;

   always #(CLK_NS/2) clk = ~clk;

   flash_read_mux dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_off(rd_off), .mode(mode),
      .wc_idle(wc_idle), .idle_wr(idle_wr), .status_ld(status_ld),
      .status_val(status_val), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .seq_reset(seq_reset), .array_mode(array_mode)
   );

   logic [15:0] mem [512];
   initial for (int i = 0; i < 512; i++) mem[i] = 16'((i * 16'h0123) ^ 16'hA5C3);
   always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

   typedef struct {
      logic [15:0] d;
      logic        sr;
      string       tag;
   } exp_t;
   exp_t q[$];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] st_model = 8'h00;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] arr(input logic [9:0] off);
      return mem[off[9:1]];
   endfunction

   // monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (q.size() == 0) begin
            chk("R1 unexpected result", 32'(rd_data), 32'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, {15'd0, seq_reset, rd_data}, {15'd0, e.sr, e.d});
         end
      end
   end

   task automatic rd(input logic [7:0] m, input logic [9:0] off, input logic wc,
                     input logic [15:0] e, input logic sr, input string tag);
      exp_t it;
      @(negedge clk);
      mode = m; rd_off = off; wc_idle = wc; rd_en = 1'b1;
      it.d = e; it.sr = sr; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_stat(input logic [7:0] m, input string tag);
      rd(m, 10'h000, 1'b1, {8'h00, st_model}, 1'b0, tag);
      st_model = st_model ^ 8'h40;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_NS * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 reset array_mode", 32'(array_mode), 32'd1);
      chk("R1 reset rd_valid", 32'(rd_valid), 32'd0);

      // R2 array reads
      rd(8'h00, 10'h010, 1'b1, arr(10'h010), 1'b0, "R2 read mode");
      rd(8'h80, 10'h3FE, 1'b1, arr(10'h3FE), 1'b0, "R2 erase pending");
      @(negedge clk);
      chk("R1 idle rd_valid", 32'(rd_valid), 32'd0);

      // R3/R4 identifier
      rd(8'h90, 10'h000, 1'b1, 16'h0001, 1'b0, "R3 ID0");
      rd(8'h90, 10'h002, 1'b1, 16'h227E, 1'b0, "R3 ID1");
      rd(8'h90, 10'h004, 1'b1, 16'h0000, 1'b0, "R3 protect word");
      rd(8'h90, 10'h01C, 1'b1, 16'h2222, 1'b0, "R4 ID2");
      rd(8'h90, 10'h01E, 1'b1, arr(10'h01E), 1'b0, "R4 ID3 fallback");
      rd(8'h90, 10'h006, 1'b1, arr(10'h006), 1'b0, "R4 other offset");
      rd(8'h90, 10'h202, 1'b1, 16'h227E, 1'b0, "R9 high bits ignored ID");
      rd(8'h98, 10'h320, 1'b1, 16'h0051, 1'b0, "R9 high bits ignored query");

      // R5 status
      @(negedge clk); status_ld = 1'b1; status_val = 8'h80;
      @(negedge clk); status_ld = 1'b0; st_model = 8'h80;
      rd_stat(8'hA0, "R5 status program");
      rd_stat(8'h10, "R5 status chip erase");
      rd_stat(8'h30, "R5 status sector erase");
      rd_stat(8'hA0, "R5 status again");

      // R6 query ROM
      rd(8'h98, 10'h020, 1'b1, 16'h0051, 1'b0, "R6 Q");
      rd(8'h98, 10'h022, 1'b1, 16'h0052, 1'b0, "R6 R");
      rd(8'h98, 10'h024, 1'b1, 16'h0059, 1'b0, "R6 Y");
      rd(8'h98, 10'h04E, 1'b1, 16'd10,   1'b0, "R6 size");
      rd(8'h98, 10'h05A, 1'b1, 16'd3,    1'b0, "R6 sectors");
      rd(8'h98, 10'h05E, 1'b1, 16'd1,    1'b0, "R6 sector size");
      rd(8'h98, 10'h0A4, 1'b1, 16'h0000, 1'b0, "R6 past table");
      rd(8'h98, 10'h0FE, 1'b1, 16'h0000, 1'b0, "R6 top offset");

      // R8 unknown mode
      rd(8'h55, 10'h040, 1'b1, arr(10'h040), 1'b1, "R8 unknown mode");
      rd(8'h00, 10'h040, 1'b1, arr(10'h040), 1'b0, "R8 no reset on known");

      // R7 lazy return
      @(negedge clk); idle_wr = 1'b1;
      @(negedge clk); idle_wr = 1'b0;
      chk("R7 idle write exit", 32'(array_mode), 32'd0);
      for (int i = 0; i < 42; i++)
         rd(8'h00, 10'(i * 2), 1'b1, arr(10'(i * 2)), 1'b0, "R7 counted read");
      chk("R7 at limit", 32'(array_mode), 32'd0);
      rd(8'h00, 10'h100, 1'b0, arr(10'h100), 1'b0, "R7 busy read");
      chk("R7 busy read not counted", 32'(array_mode), 32'd0);
      rd(8'h00, 10'h102, 1'b1, arr(10'h102), 1'b0, "R7 crossing read");
      chk("R7 return to array", 32'(array_mode), 32'd1);

      // R7 clear by idle write restarts the count
      @(negedge clk); idle_wr = 1'b1;
      @(negedge clk); idle_wr = 1'b0;
      for (int i = 0; i < 10; i++)
         rd(8'h00, 10'h010, 1'b1, arr(10'h010), 1'b0, "R7 recount");
      chk("R7 count cleared", 32'(array_mode), 32'd0);

      repeat (3) @(negedge clk);
      chk("R1 all results seen", 32'(q.size()), 32'd0);
      finish_run();
   end

endmodule